// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Controller

This block wraps a small programmable-logic core and adds an optional low-activity hold mode. The core consists of a few accumulating register cells and a few combinational cells, and it drives a bank of pad outputs, each with its own output enable. A configuration bit, captured while reset is asserted, decides the role of a single shared pin. With the option off, the pin is just one more logic input to the core. With the option on, a high level on the pin requests the hold mode.

In the hold mode the core is frozen. Input pins, output-enable pins and the core clock enable all stop reaching the core. The pad data and enables keep the values they had when the mode began, so a disabled pad stays disabled and a driving pad keeps driving its held level. Per-pin keeper registers keep the last accepted input level, so the core never sees an undefined value. The request pin passes through a two-flop synchroniser. When the pin drops, inputs are accepted again after a short recovery count, and the pads update after a longer one. A busy flag stays high from entry until the pads are live again.

Top module: `pdHoldCtrl`

## Requirements
- R1: While reset is held, and just after it, padData and padOe read all zeros and pdBusy reads 0.
- R2: With the option captured as 0, pdPin is core input bit 6 (coreIn = {pdPin, dataIn}). pdBusy never asserts, whatever level pdPin has.
- R3: cfgPdEn is captured only while rst is high. A change after reset has no effect: the pin stays a logic input and no hold occurs.
- R4: Core function, with coreIn bit 6 forced to 0 when the option is on. Each cycle tickIn is high, register cell i becomes r[i] ^ coreIn[i] ^ coreIn[(i+4) mod 7]. Combinational cell j is coreIn[j+1] ^ r[j]. padData = {comb[2:0], r[2:0]} and padOe follows oeIn.
- R5: With the option on, pdBusy rises on the third rising edge after pdPin goes high. Input, enable and tick values that change after the second such edge are never taken in.
- R6: While held, padData keeps the value it had at entry, for both the register bits and the combinational bits.
- R7: While held, padOe keeps its entry value: a disabled pad stays disabled and an enabled pad keeps driving.
- R8: Tick pulses during the hold leave the core register state unchanged. This is visible in padData once the hold ends.
- R9: After pdPin falls, padData and padOe stay frozen and pdBusy stays high through the sixth rising edge. On the seventh edge (OUT_REC+3 with defaults) pdBusy drops and the pads show the current inputs.
- R10: During recovery, a tick is ignored before IN_REC recovery cycles have elapsed and taken afterwards. Inputs are never accepted later than pad updates resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; also captures cfgPdEn |
| cfgPdEn | input | 1 | Selects pdPin as hold request (1) or logic input (0) |
| pdPin | input | 1 | Shared pin: hold request or core input bit 6 |
| dataIn | input | IN_W | Core logic inputs |
| oeIn | input | REG_N+COMB_N | Per-pad output enables |
| tickIn | input | 1 | Core clock enable |
| padData | output | REG_N+COMB_N | Pad data, register cells low, combinational cells high |
| padOe | output | REG_N+COMB_N | Pad output enables (0 = high impedance) |
| pdBusy | output | 1 | High from hold entry until pad recovery completes |

## Verification
The bench changes data, enables and tick immediately after the last edge that may still sample them. A block that captured one cycle late would show the new values in the held pads. It pulses tick during the hold and checks the register bits after release, which exposes a design that gated the outputs but left the core clocked. It samples busy and the pads on both sides of the recovery edge, so an off-by-one in either counter shows up. It also places one tick just before and one just after the input recovery point. A design with the wrong threshold then accumulates twice or not at all. Finally, the bench flips the configuration bit after reset to catch a design that reads it live.

// File: rtl/pdh_pkg.sv
package pdh_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic inPass;   // keepers load, core ticks are honoured
    logic outUpd;   // pad hold registers follow the core
    logic busy;     // hold or recovery in progress
  } pdhStrobe_t;

  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_DOWN  = 2'd1,
    PD_RECOV = 2'd2
  } pdhState_t;

endpackage

// File: rtl/pdhCtrl.sv
module pdhCtrl
  import pdh_pkg::*;
#(
  parameter int IN_REC  = 3,
  parameter int OUT_REC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgPdIn,
  input  logic       pdPin,
  output logic       cfgOn,
  output pdhStrobe_t stb
);

  localparam int CNT_W = $clog2(OUT_REC + 1) + 1;
  localparam logic [CNT_W-1:0] IN_LIM  = CNT_W'(IN_REC);
  localparam logic [CNT_W-1:0] OUT_LIM = CNT_W'(OUT_REC);

  logic syncA, syncB;
  logic pdActive;
  pdhState_t st, stNext;
  logic [CNT_W-1:0] recCnt, recCntNext;

  // Configuration captured only during reset
  always_ff @(posedge clk) begin
    if (rst) cfgOn <= cfgPdIn;
  end

  // Two-flop synchroniser on the request pin
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= pdPin;
      syncB <= syncA;
    end
  end

  assign pdActive = cfgOn & syncB;

  always_comb begin
    stNext     = st;
    recCntNext = recCnt;
    unique case (st)
      PD_RUN: begin
        if (pdActive) stNext = PD_DOWN;
      end
      PD_DOWN: begin
        if (!pdActive) begin
          stNext     = PD_RECOV;
          recCntNext = CNT_W'(1);
        end
      end
      PD_RECOV: begin
        if (pdActive) begin
          stNext = PD_DOWN;
        end else if (recCnt >= OUT_LIM) begin
          stNext = PD_RUN;
        end else begin
          recCntNext = recCnt + CNT_W'(1);
        end
      end
      default: stNext = PD_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PD_RUN;
      recCnt <= '0;
    end else begin
      st     <= stNext;
      recCnt <= recCntNext;
    end
  end

  always_comb begin
    stb.inPass = !pdActive &&
                 ((st == PD_RUN) || ((st == PD_RECOV) && (recCnt >= IN_LIM)));
    stb.outUpd = !pdActive &&
                 ((st == PD_RUN) || ((st == PD_RECOV) && (recCnt >= OUT_LIM)));
    stb.busy   = (st != PD_RUN);
  end

endmodule

// File: rtl/pdhPath.sv
module pdhPath
  import pdh_pkg::*;
#(
  parameter int IN_W   = 6,
  parameter int REG_N  = 3,
  parameter int COMB_N = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  pdhStrobe_t                stb,
  input  logic                      cfgOn,
  input  logic [IN_W-1:0]           dataIn,
  input  logic                      sharedPin,
  input  logic [REG_N+COMB_N-1:0]   oeIn,
  input  logic                      tickIn,
  output logic [REG_N+COMB_N-1:0]   padData,
  output logic [REG_N+COMB_N-1:0]   padOe,
  output logic [REG_N-1:0]          coreState,
  output logic [IN_W+REG_N+COMB_N:0] keepState
);

  localparam int CIN   = IN_W + 1;
  localparam int OUT_N = REG_N + COMB_N;

  logic [CIN-1:0]   keepIn;
  logic [OUT_N-1:0] keepOe;
  logic [CIN-1:0]   coreIn;
  logic [REG_N-1:0] regQ;
  logic [COMB_N-1:0] combQ;
  logic [OUT_N-1:0] outHold, oeHold;
  logic             coreTick;

  // Keeper registers: hold the last accepted level of every input
  always_ff @(posedge clk) begin
    if (rst) begin
      keepIn <= '0;
      keepOe <= '0;
    end else if (stb.inPass) begin
      keepIn <= {sharedPin, dataIn};
      keepOe <= oeIn;
    end
  end

  // Shared pin reaches the core only when it is a plain logic input
  assign coreIn   = {keepIn[CIN-1] & ~cfgOn, keepIn[CIN-2:0]};
  assign coreTick = tickIn & stb.inPass;

  genvar gi;
  generate
    for (gi = 0; gi < REG_N; gi++) begin : g_regCell
      always_ff @(posedge clk) begin
        if (rst) begin
          regQ[gi] <= 1'b0;
        end else if (coreTick) begin
          regQ[gi] <= regQ[gi] ^ coreIn[gi % CIN] ^ coreIn[(gi + REG_N + 1) % CIN];
        end
      end
    end
    for (gi = 0; gi < COMB_N; gi++) begin : g_combCell
      assign combQ[gi] = coreIn[(gi + 1) % CIN] ^ regQ[gi % REG_N];
    end
  endgenerate

  // Pad hold stage
  always_ff @(posedge clk) begin
    if (rst) begin
      outHold <= '0;
      oeHold  <= '0;
    end else if (stb.outUpd) begin
      outHold <= {combQ, regQ};
      oeHold  <= keepOe;
    end
  end

  assign padData   = outHold;
  assign padOe     = oeHold;
  assign coreState = regQ;
  assign keepState = {keepOe, keepIn};

endmodule

// File: rtl/pdHoldCtrl.sv
module pdHoldCtrl
  import pdh_pkg::*;
#(
  parameter int IN_W    = 6,
  parameter int REG_N   = 3,
  parameter int COMB_N  = 3,
  parameter int IN_REC  = 3,
  parameter int OUT_REC = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfgPdEn,
  input  logic                    pdPin,
  input  logic [IN_W-1:0]         dataIn,
  input  logic [REG_N+COMB_N-1:0] oeIn,
  input  logic                    tickIn,
  output logic [REG_N+COMB_N-1:0] padData,
  output logic [REG_N+COMB_N-1:0] padOe,
  output logic                    pdBusy
);

  pdhStrobe_t ctrlStb;
  logic       cfgOn;
  logic [REG_N-1:0] coreState;
  logic [IN_W+REG_N+COMB_N:0] keepState;

  pdhCtrl #(
    .IN_REC (IN_REC),
    .OUT_REC(OUT_REC)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .cfgPdIn(cfgPdEn),
    .pdPin  (pdPin),
    .cfgOn  (cfgOn),
    .stb    (ctrlStb)
  );

  pdhPath #(
    .IN_W  (IN_W),
    .REG_N (REG_N),
    .COMB_N(COMB_N)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .stb      (ctrlStb),
    .cfgOn    (cfgOn),
    .dataIn   (dataIn),
    .sharedPin(pdPin),
    .oeIn     (oeIn),
    .tickIn   (tickIn),
    .padData  (padData),
    .padOe    (padOe),
    .coreState(coreState),
    .keepState(keepState)
  );

  assign pdBusy = ctrlStb.busy;

endmodule

// File: rtl/pdhChecker.sv
module pdhChecker #(
  parameter int OUT_N  = 6,
  parameter int REG_N  = 3,
  parameter int KEEP_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              cfgOn,
  input logic              inPass,
  input logic              outUpd,
  input logic              pdBusy,
  input logic [OUT_N-1:0]  padData,
  input logic [OUT_N-1:0]  padOe,
  input logic [REG_N-1:0]  coreState,
  input logic [KEEP_W-1:0] keepState
);

  AST_OFF_NEVER_BUSY: assert property (@(posedge clk) disable iff (rst)
    !cfgOn |-> !pdBusy); // R2

  AST_ENTRY_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!pdBusy && !inPass) |=> pdBusy); // R5

  AST_KEEPER_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !inPass |=> $stable(keepState)); // R5

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !outUpd |=> $stable(padData)); // R6

  AST_OE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !outUpd |=> $stable(padOe)); // R7

  AST_CORE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !inPass |=> $stable(coreState)); // R8

  AST_INPUTS_BEFORE_PADS: assert property (@(posedge clk) disable iff (rst)
    outUpd |-> inPass); // R10

endmodule

bind pdHoldCtrl pdhChecker #(
  .OUT_N (REG_N + COMB_N),
  .REG_N (REG_N),
  .KEEP_W(IN_W + 1 + REG_N + COMB_N)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfgOn    (cfgOn),
  .inPass   (ctrlStb.inPass),
  .outUpd   (ctrlStb.outUpd),
  .pdBusy   (pdBusy),
  .padData  (padData),
  .padOe    (padOe),
  .coreState(coreState),
  .keepState(keepState)
);

// File: tb/sim_pdHoldCtrl.sv
`timescale 1ns/1ps
module sim_pdHoldCtrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfgPdEn = 1'b0;
  logic       pdPin = 1'b0;
  logic [5:0] dataIn = '0;
  logic [5:0] oeIn = '0;
  logic       tickIn = 1'b0;
  logic [5:0] padData, padOe;
  logic       pdBusy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  pdHoldCtrl u0 (
    .clk(clk), .rst(rst), .cfgPdEn(cfgPdEn), .pdPin(pdPin),
    .dataIn(dataIn), .oeIn(oeIn), .tickIn(tickIn),
    .padData(padData), .padOe(padOe), .pdBusy(pdBusy)
  );

  typedef struct {
    string      req;
    bit         useDO;
    logic [5:0] data;
    logic [5:0] oe;
    logic       busy;
  } item_t;

  item_t sbQ[$];

  // Reference model state (from the requirement text)
  logic [2:0] mReg = '0;

  function automatic logic [6:0] coreVec(logic cfg, logic pin, logic [5:0] d);
    return {pin & ~cfg, d};
  endfunction

  function automatic logic [5:0] fData(logic [6:0] ci, logic [2:0] r);
    logic [5:0] o;
    for (int j = 0; j < 3; j++) begin
      o[j]     = r[j];
      o[j + 3] = ci[j + 1] ^ r[j];
    end
    return o;
  endfunction

  function automatic logic [2:0] fTick(logic [6:0] ci, logic [2:0] r);
    logic [2:0] n;
    for (int i = 0; i < 3; i++) n[i] = r[i] ^ ci[i] ^ ci[(i + 4) % 7];
    return n;
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectItem(string req, bit useDO, logic [5:0] d, logic [5:0] o, logic b);
    item_t it;
    it.req = req; it.useDO = useDO; it.data = d; it.oe = o; it.busy = b;
    sbQ.push_back(it);
  endtask

  task automatic tickPulse();
    tickIn = 1'b1;
    step(1);
    tickIn = 1'b0;
  endtask

  task automatic doReset(logic cfg);
    rst = 1'b1;
    cfgPdEn = cfg;
    step(3);
    expectItem("R1", 1, 6'h00, 6'h00, 1'b0);
    step(1);
    rst = 1'b0;
    mReg = '0;
    step(1);
  endtask

  // Monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      checks++;
      if (pdBusy !== it.busy ||
          (it.useDO && (padData !== it.data || padOe !== it.oe))) begin
        errors++;
        $display("FAIL %s: busy=%0b data=%b oe=%b expected busy=%0b data=%b oe=%b",
                 it.req, pdBusy, padData, padOe, it.busy, it.data, it.oe);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] preD, preO, dA;
    logic [6:0] ci;
    #1;
    // R1 reset state, option off
    doReset(1'b0);

    // R4 core function, option off
    dataIn = 6'b101001; oeIn = 6'b110011; pdPin = 1'b0;
    step(4);
    ci = coreVec(1'b0, pdPin, dataIn);
    expectItem("R4", 1, fData(ci, mReg), oeIn, 1'b0);
    tickPulse();
    mReg = fTick(ci, mReg);
    step(3);
    expectItem("R4", 1, fData(ci, mReg), oeIn, 1'b0);

    // R2 shared pin as logic input, no busy
    pdPin = 1'b1;
    step(4);
    ci = coreVec(1'b0, pdPin, dataIn);
    expectItem("R2", 1, fData(ci, mReg), oeIn, 1'b0);
    tickPulse();
    mReg = fTick(ci, mReg);
    step(3);
    expectItem("R2", 1, fData(ci, mReg), oeIn, 1'b0);

    // R3 option raised after reset: no effect
    cfgPdEn = 1'b1;
    step(6);
    expectItem("R3", 1, fData(ci, mReg), oeIn, 1'b0);
    pdPin = 1'b0;
    step(4);
    ci = coreVec(1'b0, pdPin, dataIn);
    expectItem("R3", 1, fData(ci, mReg), oeIn, 1'b0);

    // Option on
    doReset(1'b1);
    dataIn = 6'b011010; oeIn = 6'b101010;
    step(4);
    ci = coreVec(1'b1, pdPin, dataIn);
    tickPulse();
    mReg = fTick(ci, mReg);
    step(3);
    preD = fData(ci, mReg); preO = oeIn;
    expectItem("R4", 1, preD, preO, 1'b0);

    // R5 entry timing, late input changes ignored
    pdPin = 1'b1;
    step(2);
    expectItem("R5", 0, 6'h00, 6'h00, 1'b0);
    dA = dataIn;
    dataIn = ~dA; oeIn = ~preO;
    step(1);
    expectItem("R5", 1, preD, preO, 1'b1);
    step(5);
    expectItem("R6", 1, preD, preO, 1'b1);
    tickPulse(); // R8: ignored
    step(3);
    expectItem("R7", 1, preD, preO, 1'b1);

    // R9 exit timing
    pdPin = 1'b0;
    step(6);
    expectItem("R9", 1, preD, preO, 1'b1);
    step(1);
    ci = coreVec(1'b1, 1'b0, dataIn);
    expectItem("R8", 1, fData(ci, mReg), oeIn, 1'b0);

    // R10 tick acceptance during recovery
    pdPin = 1'b1;
    step(8);
    pdPin = 1'b0;
    step(4);
    tickIn = 1'b1; // recovery cycle 2: ignored
    step(1);
    tickIn = 1'b1; // recovery cycle 3: taken
    step(1);
    tickIn = 1'b0;
    mReg = fTick(ci, mReg);
    step(4);
    expectItem("R10", 1, fData(ci, mReg), oeIn, 1'b0);

    step(2);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule